// File: doc/BRIEF.md
# SONET Payload Cell Extractor and Checker

This block sits on the receive side of a backplane link that carries fixed-size cells inside a concatenated SONET frame. It takes one byte per valid cycle along with a frame-start marker and a flag for transport overhead bytes. It finds cell boundaries by counting payload bytes from the first payload byte after each frame start. Each cell on the wire is a one-byte link header, then the user payload, then a one-byte parity byte. The block checks and removes the link header, checks the parity byte, and forwards only the user payload, with start and end markers.

The cell size is one of four lengths, selected by a two-bit setting that is latched at each frame start. A frame carries 37584 payload bytes. After the last whole cell, the remaining pad bytes are thrown away until the next frame start. A frame start that arrives while a cell is still open closes that cell with an error flag, and counting begins again from the new frame.

Top module: `spe_cell_extract`

## Requirements
- R1: After reset, no byte produces output until the first frame start (`in_valid` and `in_sof` both high).
- R2: Bytes with `in_oh` high are ignored. The first byte with `in_oh` low at or after a frame start is the link header of cell 0.
- R3: `cfg_size` values 0, 1, 2, 3 select total cell lengths of 77, 81, 85 and 93 bytes. The value is sampled only on the frame-start byte, so a change in mid-frame takes effect at the next frame.
- R4: The link header byte and the parity byte are never output. The user payload (total length minus 2 bytes) is output in order. `out_sop` marks its first byte and `out_eop` its last.
- R5: The parity byte must equal the XOR of all user payload bytes of the cell. A mismatch raises `out_bip_err` together with that cell's `out_eop`.
- R6: Header bit 7 is a valid bit and bits 6:0 are a sequence number. The header is in error if bit 7 is 0, or if the sequence number is not the previous header's number plus 1 modulo 128. The first header after reset is accepted with any number, and every header, good or bad, becomes the new previous number. An error raises `out_hdr_err` together with that cell's `out_eop`.
- R7: A frame holds floor(37584 / length) cells: 488, 464, 442 and 404 cells, leaving 8, 0, 14 and 12 pad bytes. Pad bytes, and any bytes beyond them, produce no output until the next frame start.
- R8: If a frame start arrives after a cell has output at least one payload byte but before its parity byte, the last payload byte already received is output with `out_eop` and `out_bip_err` set. The new frame is then delineated from its first payload byte.
- R9: Cycles with `in_valid` low change no state, and no output follows them in the next cycle.
- R10: The error flags are only ever high on an `out_eop` beat, and `out_sop` beats and `out_eop` beats strictly alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Cell length select, sampled at frame start |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_oh | input | 1 | Byte belongs to transport overhead |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Output payload byte is valid |
| out_data | output | 8 | User payload byte |
| out_sop | output | 1 | First payload byte of a cell |
| out_eop | output | 1 | Last payload byte of a cell |
| out_bip_err | output | 1 | Parity mismatch or truncated cell, on the end beat |
| out_hdr_err | output | 1 | Link header invalid or out of sequence, on the end beat |

## Verification
The pad region and the cell-count wrap at the end of a frame are the hardest states to reach, because they exist only after tens of thousands of payload bytes. The stimulus therefore streams whole frames for three of the four sizes. It sprinkles overhead bytes and idle cycles through the payload, and adds extra bytes after the pad, so the last cell, the dropped pad and the idle state are all exercised. A truncated cell is produced by issuing a frame start partway through a cell. A header-only fragment cut off the same way shows that a frame start with no buffered payload produces no output.

// File: rtl/cellx_pkg.sv
package cellx_pkg;

  localparam int BYTE_W = 8;
  localparam int POS_W  = 7;
  localparam int SEQ_W  = 7;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_CELL = 2'd1,
    TRK_PAD  = 2'd2
  } trk_state_e;

  // Total cell length on the link, header and parity included.
  function automatic logic [POS_W-1:0] cell_len(input logic [SEL_W-1:0] sel);
    logic [POS_W-1:0] len;
    case (sel)
      2'd0:    len = POS_W'(77);
      2'd1:    len = POS_W'(81);
      2'd2:    len = POS_W'(85);
      default: len = POS_W'(93);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/cellx_tracker.sv
module cellx_tracker
  import cellx_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 37584
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_size,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_oh,
  output logic             is_hdr,
  output logic             is_pay,
  output logic             is_bip,
  output logic             first_pay,
  output logic             frame_cut
);

  localparam int CPF0  = PAYLOAD_BYTES / 77;
  localparam int CPF1  = PAYLOAD_BYTES / 81;
  localparam int CPF2  = PAYLOAD_BYTES / 85;
  localparam int CPF3  = PAYLOAD_BYTES / 93;
  localparam int CNT_W = $clog2(CPF0 + 1);

  function automatic logic [CNT_W-1:0] cells_per(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = CNT_W'(CPF0);
      2'd1:    n = CNT_W'(CPF1);
      2'd2:    n = CNT_W'(CPF2);
      default: n = CNT_W'(CPF3);
    endcase
    return n;
  endfunction

  trk_state_e       st_q, st_d, st_e;
  logic [POS_W-1:0] pos_q, pos_d, pos_e;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_e;
  logic [SEL_W-1:0] sel_q, sel_e;
  logic [POS_W-1:0] len_e;
  logic             sof_hit, accept, last_cell;

  assign sof_hit = in_valid && in_sof;

  // A frame start overrides the tracked position within the same cycle.
  always_comb begin
    if (sof_hit) begin
      st_e  = TRK_CELL;
      pos_e = '0;
      cnt_e = '0;
      sel_e = cfg_size;
    end else begin
      st_e  = st_q;
      pos_e = pos_q;
      cnt_e = cnt_q;
      sel_e = sel_q;
    end
  end

  assign len_e     = cell_len(sel_e);
  assign accept    = in_valid && !in_oh && (st_e == TRK_CELL);
  assign is_hdr    = accept && (pos_e == '0);
  assign is_bip    = accept && (pos_e == len_e - POS_W'(1));
  assign is_pay    = accept && !is_hdr && !is_bip;
  assign first_pay = is_pay && (pos_e == POS_W'(1));
  assign frame_cut = sof_hit && (st_q == TRK_CELL) && (pos_q != '0);
  assign last_cell = (cnt_e + CNT_W'(1)) == cells_per(sel_e);

  always_comb begin
    st_d  = st_e;
    pos_d = pos_e;
    cnt_d = cnt_e;
    if (is_bip) begin
      pos_d = '0;
      cnt_d = cnt_e + CNT_W'(1);
      if (last_cell) st_d = TRK_PAD;
    end else if (accept) begin
      pos_d = pos_e + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRK_IDLE;
      pos_q <= '0;
      cnt_q <= '0;
      sel_q <= '0;
    end else if (in_valid) begin
      st_q  <= st_d;
      pos_q <= pos_d;
      cnt_q <= cnt_d;
      sel_q <= sel_e;
    end
  end

  a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_CELL) |-> (pos_q < cell_len(sel_q)));

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cells_per(sel_q));

  a_r7_pad_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_PAD && !sof_hit) |=> (st_q == TRK_PAD));

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_IDLE && !sof_hit) |=> (st_q == TRK_IDLE));

  a_r9_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pos_q) && $stable(cnt_q)));

endmodule

// File: rtl/cellx_checker.sv
module cellx_checker
  import cellx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_hdr,
  input  logic              is_pay,
  input  logic              is_bip,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              hdr_err,
  output logic              bip_bad
);

  logic              seen_q, seen_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic              herr_q, herr_d;
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic              hdr_fault;

  assign hdr_fault = !in_byte[BYTE_W-1] ||
                     (seen_q && (in_byte[SEQ_W-1:0] != seq_q + SEQ_W'(1)));

  always_comb begin
    seen_d = seen_q;
    seq_d  = seq_q;
    herr_d = herr_q;
    acc_d  = acc_q;
    if (is_hdr) begin
      seen_d = 1'b1;
      seq_d  = in_byte[SEQ_W-1:0];
      herr_d = hdr_fault;
      acc_d  = '0;
    end else if (is_pay) begin
      acc_d  = acc_q ^ in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      seq_q  <= '0;
      herr_q <= 1'b0;
      acc_q  <= '0;
    end else if (is_hdr || is_pay) begin
      seen_q <= seen_d;
      seq_q  <= seq_d;
      herr_q <= herr_d;
      acc_q  <= acc_d;
    end
  end

  assign hdr_err = herr_q;
  assign bip_bad = is_bip && (acc_q != in_byte);

  a_r6_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hdr && !in_byte[BYTE_W-1]) |=> herr_q);

  a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    is_hdr |=> (acc_q == '0));

endmodule

// File: rtl/spe_cell_extract.sv
module spe_cell_extract
  import cellx_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 37584
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_size,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_oh,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_bip_err,
  output logic              out_hdr_err
);

  logic is_hdr, is_pay, is_bip, first_pay, frame_cut;
  logic hdr_err, bip_bad;

  cellx_tracker #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_size  (cfg_size),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_oh     (in_oh),
    .is_hdr    (is_hdr),
    .is_pay    (is_pay),
    .is_bip    (is_bip),
    .first_pay (first_pay),
    .frame_cut (frame_cut)
  );

  cellx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_hdr  (is_hdr),
    .is_pay  (is_pay),
    .is_bip  (is_bip),
    .in_byte (in_byte),
    .hdr_err (hdr_err),
    .bip_bad (bip_bad)
  );

  // One-byte hold stage so the final payload byte leaves with its verdict.
  logic              held_vld_q, held_vld_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              held_sop_q, held_sop_d;
  logic              emit_mid, emit_end, emit_cut, emit_any;
  logic              ov_d, osop_d, oeop_d, obip_d, ohdr_d;

  assign emit_mid = is_pay && held_vld_q;
  assign emit_end = is_bip && held_vld_q;
  assign emit_cut = frame_cut && held_vld_q;
  assign emit_any = emit_mid || emit_end || emit_cut;

  always_comb begin
    held_vld_d = held_vld_q;
    held_d     = held_q;
    held_sop_d = held_sop_q;
    if (is_pay) begin
      held_vld_d = 1'b1;
      held_d     = in_byte;
      held_sop_d = first_pay;
    end else if (is_bip || (in_valid && in_sof)) begin
      held_vld_d = 1'b0;
    end
    ov_d   = emit_any;
    osop_d = held_sop_q;
    oeop_d = emit_end || emit_cut;
    obip_d = emit_end ? bip_bad : emit_cut;
    ohdr_d = (emit_end || emit_cut) && hdr_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld_q <= 1'b0;
      held_q     <= '0;
      held_sop_q <= 1'b0;
    end else if (in_valid) begin
      held_vld_q <= held_vld_d;
      held_q     <= held_d;
      held_sop_q <= held_sop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_bip_err <= 1'b0;
      out_hdr_err <= 1'b0;
    end else begin
      out_valid   <= ov_d;
      out_sop     <= ov_d && osop_d;
      out_eop     <= oeop_d;
      out_bip_err <= obip_d;
      out_hdr_err <= ohdr_d;
      if (ov_d) out_data <= held_q;
    end
  end

  // Cell framing tracker for the output checks below.
  logic mid_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mid_q <= 1'b0;
    else if (out_valid) mid_q <= !out_eop;
  end

  a_r10_flags_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bip_err || out_hdr_err) |-> (out_valid && out_eop));

  a_r10_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !mid_q);

  a_r10_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> mid_q);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_cut_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && held_vld_q) |=> (out_valid && out_eop && out_bip_err));

endmodule

// File: tb/test_spe_cell_extract.sv
module test_spe_cell_extract;

  logic       clk;
  logic       rst_n;
  logic [1:0] cfg_size;
  logic       in_valid, in_sof, in_oh;
  logic [7:0] in_byte;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop, out_eop, out_bip_err, out_hdr_err;

  spe_cell_extract i_spe_cell_extract (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_size    (cfg_size),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_oh       (in_oh),
    .in_byte     (in_byte),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_bip_err (out_bip_err),
    .out_hdr_err (out_hdr_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [11:0] exp_q[$];
  int eop_seen = 0;
  int out_seen = 0;

  int unsigned gcount = 0;
  int unsigned cell_no = 0;
  bit          have_prev = 0;
  logic [6:0]  prev_seq = '0;

  function automatic int total_len(input int sel);
    case (sel)
      0: return 77;
      1: return 81;
      2: return 85;
      default: return 93;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: compare every output beat with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      logic [11:0] got, expv;
      got = {out_hdr_err, out_bip_err, out_eop, out_sop, out_data};
      out_seen++;
      if (out_eop) eop_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected output", int'(got), -1);
      end else begin
        expv = exp_q.pop_front();
        if (got[10] != expv[10])      check(1'b0, "R5 bip flag", int'(got), int'(expv));
        else if (got[11] != expv[11]) check(1'b0, "R6 hdr flag", int'(got), int'(expv));
        else                          check(got == expv, "R4 R10 payload beat", int'(got), int'(expv));
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit s, input bit e, input bit b, input bit h);
    exp_q.push_back({h, b, e, s, d});
  endtask

  task automatic drive(input logic [7:0] b, input bit sof, input bit oh);
    in_valid = 1'b1; in_byte = b; in_sof = sof; in_oh = oh;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_oh = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_byte = 8'hA5;
      @(negedge clk);
    end
  endtask

  // Payload byte; interleaves overhead bytes (R2) and idle cycles (R9).
  task automatic pay(input logic [7:0] b);
    gcount++;
    if (gcount % 700 == 0) drive(8'h3C, 1'b0, 1'b1);
    if (gcount % 997 == 0) idle(1);
    drive(b, 1'b0, 1'b0);
  endtask

  task automatic start_frame(input int sel);
    cfg_size = 2'(sel);
    drive(8'hF6, 1'b1, 1'b1);
    drive(8'hF6, 1'b0, 1'b1);
    drive(8'h28, 1'b0, 1'b1);
  endtask

  // k < 0: whole cell; k >= 0: header plus k payload bytes, then cut off.
  task automatic send_cell(input int sel, input bit bip_bad, input bit hdr_inv,
                           input bit seq_skip, input int k);
    int         n, cnt;
    logic [6:0] seq;
    logic [7:0] x, b;
    bit         eh;
    n   = total_len(sel) - 2;
    seq = have_prev ? prev_seq + 7'd1 : 7'd5;
    if (seq_skip) seq = seq + 7'd2;
    eh  = hdr_inv || (have_prev && seq_skip);
    have_prev = 1;
    prev_seq  = seq;
    pay({~hdr_inv, seq});
    cnt = (k < 0) ? n : k;
    x = '0;
    for (int i = 0; i < cnt; i++) begin
      b = 8'((cell_no * 31 + i * 7 + 3) & 255);
      x = x ^ b;
      push(b, i == 0, i == cnt - 1,
           (i == cnt - 1) ? ((k < 0) ? bip_bad : 1'b1) : 1'b0,
           (i == cnt - 1) ? eh : 1'b0);
      pay(b);
    end
    if (k < 0) pay(bip_bad ? (x ^ 8'h01) : x);
    cell_no++;
  endtask

  task automatic full_frame(input int sel, input int extra, input bit cfg_flip);
    int len, cpf, pad, base;
    len  = total_len(sel);
    cpf  = 37584 / len;
    pad  = 37584 - cpf * len;
    base = eop_seen;
    start_frame(sel);
    for (int c = 0; c < cpf; c++) begin
      if (cfg_flip && c == 3) cfg_size = 2'(3 - sel); // R3: ignored until next frame start
      send_cell(sel, c == 2, c == 5, c == 9, -1);
    end
    for (int p = 0; p < pad + extra; p++) pay(8'h80 | 8'(p)); // R7 pad and surplus dropped
    idle(4);
    check(eop_seen - base == cpf, "R7 R3 cells per frame", eop_seen - base, cpf);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; cfg_size = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_oh = 1'b0; in_byte = '0;
    repeat (3) @(negedge clk);
    // Reset state
    check(out_valid == 1'b0 && out_eop == 1'b0, "R10 reset outputs", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bytes before the first frame start are dropped
    for (int i = 0; i < 12; i++) drive(8'(8'h81 + i), 1'b0, 1'b0);
    idle(3);
    check(out_seen == 0, "R1 no output before frame start", out_seen, 0);

    // Size 77 with injected parity, invalid header and sequence skip; size flip mid-frame
    full_frame(0, 0, 1'b1);
    // Size 93 with extra bytes beyond the pad
    full_frame(3, 20, 1'b0);
    // Size 85
    full_frame(2, 0, 1'b0);

    // R8: truncated cell with buffered payload
    base = eop_seen;
    start_frame(1);
    for (int c = 0; c < 5; c++) send_cell(1, 1'b0, 1'b0, 1'b0, -1);
    send_cell(1, 1'b0, 1'b0, 1'b0, 30);
    start_frame(1);
    idle(3);
    check(eop_seen - base == 6, "R8 cut cell closed", eop_seen - base, 6);

    // R8: header-only fragment yields nothing, next frame delineates cleanly
    base = eop_seen;
    for (int c = 0; c < 3; c++) send_cell(1, 1'b0, 1'b0, 1'b0, -1);
    send_cell(1, 1'b0, 1'b0, 1'b0, 0);
    start_frame(1);
    for (int c = 0; c < 2; c++) send_cell(1, 1'b0, 1'b0, 1'b0, -1);
    idle(6);
    check(eop_seen - base == 5, "R8 header-only fragment", eop_seen - base, 5);

    // R2 R9: overhead and idle insertions left the stream intact
    check(exp_q.size() == 0, "R2 R9 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule